// File: doc/BRIEF.md
# Banked GPIO Controller with Movable Index/Data Window

This block controls 22 general-purpose pins grouped into three banks of 8, 6 and 8 pins, numbered 10-17, 20-25 and 30-37. Software never reaches pin data at a fixed address. It first writes a bank number into an index port, then reads or writes the matching data port. A global window register, written through the configuration interface, turns this index/data pair on and places it at one of four address pairs on the 8-bit I/O bus.

Each pin has its own configuration byte, held in the register space of logical device 8. The byte sets the pin's direction and its polarity inversion. It can also hand the pad to a special-function source, which bypasses the data latch. The pad side is purely digital: an output value, an output enable and the sampled input for each pin. A pair of special-function signals (one in, one out) passes through to the pin's alternate function.

Neither bus has back-pressure. An I/O write completes in the cycle `io_wr` is high. An I/O read taken in one cycle returns its data with a one-cycle `io_rvalid` pulse on the next cycle. Configuration writes take effect on the next clock edge. Configuration reads are combinational.

Top module: `gpio_win_ctrl`

## Requirements
- R1: After reset, every pin configuration byte reads 0x01 (input, normal polarity, normal function). The global window register reads 0x00, no pad is driven (`pad_oe` all 0), and all data latches are 0.
- R2: While global bit 7 is 0, the window is closed. Every I/O read returns 0x00 and every I/O write is ignored, including writes to the index port and to the data latches.
- R3: Global bits 1:0 place the window. Value 0 puts index/data at 0xE0/0xE1, 1 at 0xE2/0xE3, 2 at 0xE4/0xE5 and 3 at 0xEA/0xEB. Reads at any other I/O address return 0x00.
- R4: The index port stores and reads back a full byte. Index 0x01 selects pins 10-17 (bit n = pin 1n), 0x02 selects pins 20-25 (bits 5:0), and 0x03 selects pins 30-37. With any other index, data reads return 0x00 and data writes are ignored.
- R5: Configuration writes with `cfg_global`=0 and `cfg_ldn`=0x08 reach the pin bytes. Pin 1n is at 0xE0+n, pin 2n at 0xE8+n and pin 3n at 0xF5+n. Bit 0 is direction (1 = input), bit 1 is polarity (1 = inverted) and bit 3 is special function. Other bits read 0. Other addresses and other logical devices read 0x00 and are ignored on write.
- R6: A data-port read returns, for each pin of the selected bank, the pad input XOR the pin's polarity bit. Bits 7:6 of bank 2 read 0.
- R7: `pad_oe` of a pin is 1 exactly when its direction bit is 0. In normal function, an output pin drives latch XOR polarity on `pad_out`, and an input pin drives 0.
- R8: With the special bit set, `pad_out` follows `sf_out` and the data latch has no effect. `sf_in` always carries the raw `pad_in`.
- R9: `io_rvalid` pulses high for the one cycle after each cycle with `io_rd` high. `io_rdata` holds its value until the next read.
- R10: With `cfg_global`=1, address 0x03 is the window register. Only bits 7 and 1:0 are stored and read back. Other global addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O bus address |
| io_wdata | input | 8 | I/O bus write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Read data, registered |
| io_rvalid | output | 1 | Read data valid pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_global | input | 1 | 1 selects global registers, 0 the logical-device space |
| cfg_ldn | input | 8 | Logical device number for device-space accesses |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational |
| pad_in | input | 22 | Sampled pad inputs, pin 10 at bit 0 up to pin 37 at bit 21 |
| pad_out | output | 22 | Pad output values |
| pad_oe | output | 22 | Pad output enables |
| sf_out | input | 22 | Special-function output values |
| sf_in | output | 22 | Pad inputs delivered to special functions |

## Verification
The bench sweeps the window placement over all four settings. At each setting it probes the three addresses that belong to the other settings, which separates a correct decode from an aliased one. Every address from 0xE0 to 0xFF is written with a distinct byte and read back, which exposes gaps or overlaps in the pin configuration map. Pad and latch values are driven with all-zero, all-one, alternating and pseudo-random patterns, with a polarity mask that mixes inverted and plain pins, so a swapped slice, a missing XOR or a leak into the unused bank-2 bits shows up. A mix of normal input, normal output and special pins, with a latch rewrite in between, tells the special-function bypass apart from the latched path.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;
  localparam int B0_W   = 8;
  localparam int B1_W   = 6;
  localparam int B2_W   = 8;
  localparam int NPINS  = B0_W + B1_W + B2_W;
  localparam int B1_OFF = B0_W;
  localparam int B2_OFF = B0_W + B1_W;
  localparam int PIDX_W = $clog2(NPINS);

  localparam logic [7:0] CFG_BASE0  = 8'hE0;
  localparam logic [7:0] CFG_BASE1  = 8'hE8;
  localparam logic [7:0] CFG_BASE2  = 8'hF5;
  localparam logic [7:0] WIN_REG    = 8'h03;
  localparam logic [7:0] PIN_DEV    = 8'h08;
  localparam logic [7:0] IDX_BANK0  = 8'h01;
  localparam logic [7:0] IDX_BANK1  = 8'h02;
  localparam logic [7:0] IDX_BANK2  = 8'h03;

  typedef struct packed {
    logic              hit;
    logic [PIDX_W-1:0] idx;
  } pin_sel_t;

  // Maps a device-space address to a flat pin index.
  function automatic pin_sel_t cfg_lookup(input logic [7:0] a);
    pin_sel_t r;
    r = '0;
    if (a >= CFG_BASE0 && a < CFG_BASE0 + 8'(B0_W)) begin
      r.hit = 1'b1;
      r.idx = PIDX_W'(a - CFG_BASE0);
    end else if (a >= CFG_BASE1 && a < CFG_BASE1 + 8'(B1_W)) begin
      r.hit = 1'b1;
      r.idx = PIDX_W'(a - CFG_BASE1 + 8'(B1_OFF));
    end else if (a >= CFG_BASE2 && a < CFG_BASE2 + 8'(B2_W)) begin
      r.hit = 1'b1;
      r.idx = PIDX_W'(a - CFG_BASE2 + 8'(B2_OFF));
    end
    return r;
  endfunction

  // Index-port address for each window placement; data port is +1.
  function automatic logic [7:0] win_base(input logic [1:0] s);
    case (s)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction
endpackage

// File: rtl/gpio_win_port.sv
module gpio_win_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          win_en,
  input  logic [1:0]    win_sel,
  output logic [DW-1:0] idx_q,
  output logic          hit_index,
  output logic          hit_data
);
  import gpio_win_pkg::*;

  logic [AW-1:0] base;

  assign base      = AW'(win_base(win_sel));
  assign hit_index = win_en && (io_addr == base);
  assign hit_data  = win_en && (io_addr == base + AW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  idx_q <= '0;
    else if (io_wr && hit_index) idx_q <= io_wdata;
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int NP = 22,
  parameter int IW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hit,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_hit,
  input  logic [IW-1:0] rd_idx,
  output logic [NP-1:0] dir_in,
  output logic [NP-1:0] pol_inv,
  output logic [NP-1:0] spec_en,
  output logic [DW-1:0] rd_byte
);
  localparam int BIT_DIR  = 0;
  localparam int BIT_POL  = 1;
  localparam int BIT_SPEC = 3;

  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic sel;
    assign sel = wr_en && wr_hit && (wr_idx == IW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_in[p]  <= 1'b1;
        pol_inv[p] <= 1'b0;
        spec_en[p] <= 1'b0;
      end else if (sel) begin
        dir_in[p]  <= wr_data[BIT_DIR];
        pol_inv[p] <= wr_data[BIT_POL];
        spec_en[p] <= wr_data[BIT_SPEC];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int p = 0; p < NP; p++) begin
      if (rd_hit && rd_idx == IW'(p)) begin
        rd_byte[BIT_DIR]  = dir_in[p];
        rd_byte[BIT_POL]  = pol_inv[p];
        rd_byte[BIT_SPEC] = spec_en[p];
      end
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NP = 22
) (
  input  logic [NP-1:0] latch,
  input  logic [NP-1:0] dir_in,
  input  logic [NP-1:0] pol_inv,
  input  logic [NP-1:0] spec_en,
  input  logic [NP-1:0] sf_out,
  input  logic [NP-1:0] pad_in,
  output logic [NP-1:0] pad_out,
  output logic [NP-1:0] pad_oe,
  output logic [NP-1:0] sf_in,
  output logic [NP-1:0] pin_view
);
  for (genvar p = 0; p < NP; p++) begin : g_pin
    assign pad_oe[p]   = ~dir_in[p];
    assign pad_out[p]  = spec_en[p] ? sf_out[p]
                       : (dir_in[p] ? 1'b0 : (latch[p] ^ pol_inv[p]));
    assign sf_in[p]    = pad_in[p];
    assign pin_view[p] = pad_in[p] ^ pol_inv[p];
  end
endmodule

// File: rtl/gpio_win_ctrl.sv
module gpio_win_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  io_addr,
  input  logic [DW-1:0]                  io_wdata,
  input  logic                           io_wr,
  input  logic                           io_rd,
  output logic [DW-1:0]                  io_rdata,
  output logic                           io_rvalid,
  input  logic                           cfg_wr,
  input  logic                           cfg_global,
  input  logic [7:0]                     cfg_ldn,
  input  logic [7:0]                     cfg_addr,
  input  logic [DW-1:0]                  cfg_wdata,
  output logic [DW-1:0]                  cfg_rdata,
  input  logic [gpio_win_pkg::NPINS-1:0] pad_in,
  output logic [gpio_win_pkg::NPINS-1:0] pad_out,
  output logic [gpio_win_pkg::NPINS-1:0] pad_oe,
  input  logic [gpio_win_pkg::NPINS-1:0] sf_out,
  output logic [gpio_win_pkg::NPINS-1:0] sf_in
);
  import gpio_win_pkg::*;

  localparam int EN_BIT = DW - 1;

  // Global window register.
  logic       win_en;
  logic [1:0] win_sel;
  logic       glob_hit;

  assign glob_hit = cfg_global && (cfg_addr == WIN_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en  <= 1'b0;
      win_sel <= 2'd0;
    end else if (cfg_wr && glob_hit) begin
      win_en  <= cfg_wdata[EN_BIT];
      win_sel <= cfg_wdata[1:0];
    end
  end

  // Pin configuration space.
  pin_sel_t      csel;
  logic          dev_hit;
  logic [DW-1:0] pin_cfg_byte;
  logic [NPINS-1:0] cfg_dir, cfg_pol, cfg_spec;

  assign csel    = cfg_lookup(cfg_addr);
  assign dev_hit = !cfg_global && (cfg_ldn == PIN_DEV) && csel.hit;

  gpio_cfg_bank #(.NP(NPINS), .IW(PIDX_W), .DW(DW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_hit  (dev_hit),
    .wr_idx  (csel.idx),
    .wr_data (cfg_wdata),
    .rd_hit  (dev_hit),
    .rd_idx  (csel.idx),
    .dir_in  (cfg_dir),
    .pol_inv (cfg_pol),
    .spec_en (cfg_spec),
    .rd_byte (pin_cfg_byte)
  );

  always_comb begin
    cfg_rdata = '0;
    if (glob_hit) begin
      cfg_rdata[EN_BIT] = win_en;
      cfg_rdata[1:0]    = win_sel;
    end else if (dev_hit) begin
      cfg_rdata = pin_cfg_byte;
    end
  end

  // Index/data window.
  logic [DW-1:0] idx_q;
  logic          hit_index, hit_data;

  gpio_win_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_wr     (io_wr),
    .win_en    (win_en),
    .win_sel   (win_sel),
    .idx_q     (idx_q),
    .hit_index (hit_index),
    .hit_data  (hit_data)
  );

  // Output data latches, one bank slice per index value.
  logic [NPINS-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '0;
    else if (io_wr && hit_data) begin
      case (idx_q)
        IDX_BANK0: latch_q[B0_W-1:0]          <= io_wdata[B0_W-1:0];
        IDX_BANK1: latch_q[B1_OFF+:B1_W]      <= io_wdata[B1_W-1:0];
        IDX_BANK2: latch_q[B2_OFF+:B2_W]      <= io_wdata[B2_W-1:0];
        default:   latch_q                    <= latch_q;
      endcase
    end
  end

  // Pad multiplexer.
  logic [NPINS-1:0] pin_view;

  gpio_pad_mux #(.NP(NPINS)) u_pads (
    .latch    (latch_q),
    .dir_in   (cfg_dir),
    .pol_inv  (cfg_pol),
    .spec_en  (cfg_spec),
    .sf_out   (sf_out),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .sf_in    (sf_in),
    .pin_view (pin_view)
  );

  // Read return path.
  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (hit_index) rd_next = idx_q;
    else if (hit_data) begin
      case (idx_q)
        IDX_BANK0: rd_next = DW'(pin_view[B0_W-1:0]);
        IDX_BANK1: rd_next = DW'(pin_view[B1_OFF+:B1_W]);
        IDX_BANK2: rd_next = DW'(pin_view[B2_OFF+:B2_W]);
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gpio_win_chk.sv
module gpio_win_chk #(
  parameter int NP = 22,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_rd,
  input logic          io_wr,
  input logic [DW-1:0] io_rdata,
  input logic          io_rvalid,
  input logic          win_en,
  input logic [NP-1:0] latch_q,
  input logic [NP-1:0] cfg_dir,
  input logic [NP-1:0] cfg_pol,
  input logic [NP-1:0] cfg_spec,
  input logic [NP-1:0] sf_out,
  input logic [NP-1:0] pad_out,
  input logic [NP-1:0] pad_oe
);
  assert_oe_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & cfg_dir) == '0);

  assert_normal_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ latch_q ^ cfg_pol) & ~cfg_spec & ~cfg_dir) == '0);

  assert_special_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ sf_out) & cfg_spec) == '0);

  assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> io_rvalid);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> !io_rvalid);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_closed_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !win_en) |=> io_rdata == '0);

  assert_closed_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !win_en) |=> $stable(latch_q));
endmodule

bind gpio_win_ctrl gpio_win_chk #(.NP(gpio_win_pkg::NPINS), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_rdata  (io_rdata),
  .io_rvalid (io_rvalid),
  .win_en    (win_en),
  .latch_q   (latch_q),
  .cfg_dir   (cfg_dir),
  .cfg_pol   (cfg_pol),
  .cfg_spec  (cfg_spec),
  .sf_out    (sf_out),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/sim_gpio_win_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_win_ctrl;
  localparam int NP = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic io_wr = 1'b0, io_rd = 1'b0, io_rvalid;
  logic cfg_wr = 1'b0, cfg_global = 1'b0;
  logic [7:0] cfg_ldn = '0, cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, sf_out = '0, sf_in;

  always #10 clk = ~clk;

  gpio_win_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_wr(cfg_wr), .cfg_global(cfg_global), .cfg_ldn(cfg_ldn),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .sf_out(sf_out), .sf_in(sf_in)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] cfg_m [NP];
  logic [NP-1:0] latch_m = '0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic logic [7:0] pin_addr(input int p);
    if (p < 8) return 8'hE0 + 8'(p);
    if (p < 14) return 8'hE8 + 8'(p - 8);
    return 8'hF5 + 8'(p - 14);
  endfunction

  function automatic logic [7:0] base_of(input int s);
    case (s)
      0: return 8'hE0;
      1: return 8'hE2;
      2: return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

  function automatic logic [NP-1:0] vec(input int b);
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = cfg_m[p][b];
    return v;
  endfunction

  function automatic logic [7:0] exp_bank(input int k);
    logic [NP-1:0] v;
    v = pad_in ^ vec(1);
    if (k == 1) return v[7:0];
    if (k == 2) return {2'b00, v[13:8]};
    if (k == 3) return v[21:14];
    return 8'h00;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] r, d, pl, sp;
    d = vec(0); pl = vec(1); sp = vec(3);
    for (int p = 0; p < NP; p++)
      r[p] = sp[p] ? sf_out[p] : (d[p] ? 1'b0 : (latch_m[p] ^ pl[p]));
    return r;
  endfunction

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata; v = io_rvalid;
  endtask

  task automatic cfg_write(input logic g, input logic [7:0] ldn, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_global = g; cfg_ldn = ldn; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic g, input logic [7:0] ldn, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_global = g; cfg_ldn = ldn; cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_pin(input int p, input logic [7:0] v);
    cfg_write(1'b0, 8'h08, pin_addr(p), v);
    cfg_m[p] = v & 8'h0B;
  endtask

  task automatic check_pads(input string tag);
    #1;
    check(pad_out == exp_out(), {tag, " pad_out"}, 32'(pad_out), 32'(exp_out()));
    check(pad_oe == ~vec(0), {tag, " pad_oe"}, 32'(pad_oe), 32'(~vec(0)));
  endtask

  initial begin
    #(200000 * 20);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    for (int p = 0; p < NP; p++) cfg_m[p] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      cfg_read(1'b0, 8'h08, pin_addr(p), d);
      check(d == 8'h01, "R1 cfg reset", 32'(d), 32'h01);
    end
    cfg_read(1'b1, 8'h00, 8'h03, d);
    check(d == 8'h00, "R1 global reset", 32'(d), 32'h00);
    check(pad_oe == '0, "R1 pad_oe reset", 32'(pad_oe), 32'h0);

    // R2: closed window ignores reads and writes
    io_write(8'hE0, 8'h03);
    io_read(8'hE0, d, v);
    check(d == 8'h00, "R2 closed read", 32'(d), 32'h00);
    cfg_write(1'b1, 8'h00, 8'h03, 8'h80);
    io_read(8'hE0, d, v);
    check(d == 8'h00, "R2 index write ignored", 32'(d), 32'h00);

    // R3/R4/R6: window placement sweep
    for (int s = 0; s < 4; s++) begin
      cfg_write(1'b1, 8'h00, 8'h03, 8'h80 | 8'(s));
      io_write(base_of(s), 8'h03);
      io_read(base_of(s), d, v);
      check(d == 8'h03, "R4 index readback", 32'(d), 32'h03);
      seed = nxt(seed); pad_in = seed[NP-1:0];
      io_read(base_of(s) + 8'h01, d, v);
      check(d == exp_bank(3), "R3 data port", 32'(d), 32'(exp_bank(3)));
      for (int o = 0; o < 4; o++) begin
        if (o != s) begin
          io_read(base_of(o) + 8'h01, d, v);
          check(d == 8'h00, "R3 foreign address", 32'(d), 32'h00);
        end
      end
    end

    // R5/R10: full configuration address sweep
    for (int a = 8'hE0; a <= 8'hFF; a++) cfg_write(1'b0, 8'h08, 8'(a), 8'(a * 37) ^ 8'h5A);
    for (int p = 0; p < NP; p++) cfg_m[p] = (8'(pin_addr(p) * 37) ^ 8'h5A) & 8'h0B;
    for (int p = 0; p < NP; p++) cfg_write(1'b0, 8'h07, pin_addr(p), 8'hFF);
    for (int a = 8'hE0; a <= 8'hFF; a++) begin
      logic [7:0] e;
      e = 8'h00;
      for (int p = 0; p < NP; p++) if (pin_addr(p) == 8'(a)) e = cfg_m[p];
      cfg_read(1'b0, 8'h08, 8'(a), d);
      check(d == e, "R5 cfg map", 32'(d), 32'(e));
    end
    cfg_read(1'b0, 8'h07, 8'hE0, d);
    check(d == 8'h00, "R5 other device", 32'(d), 32'h00);
    cfg_write(1'b1, 8'h00, 8'h03, 8'hFF);
    cfg_read(1'b1, 8'h00, 8'h03, d);
    check(d == 8'h83, "R10 global mask", 32'(d), 32'h83);
    cfg_read(1'b1, 8'h00, 8'h04, d);
    check(d == 8'h00, "R10 other global", 32'(d), 32'h00);

    // R6/R4: input sweep with mixed polarity
    for (int p = 0; p < NP; p++) set_pin(p, (p % 3 == 0) ? 8'h03 : 8'h01);
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed);
      case (i)
        0: pad_in = '0;
        1: pad_in = '1;
        2: pad_in = 22'h2AAAAA;
        default: pad_in = seed[NP-1:0];
      endcase
      for (int k = 0; k < 5; k++) begin
        io_write(8'hEA, 8'(k));
        io_read(8'hEB, d, v);
        check(d == exp_bank(k), (k == 0 || k == 4) ? "R4 bad index read" : "R6 bank read",
              32'(d), 32'(exp_bank(k)));
      end
      check(sf_in == pad_in, "R8 sf_in", 32'(sf_in), 32'(pad_in));
    end

    // R7/R4: output sweep
    for (int p = 0; p < NP; p++) set_pin(p, (p % 4 == 1) ? 8'h02 : 8'h00);
    check_pads("R7 latches zero");
    for (int i = 0; i < 6; i++) begin
      seed = nxt(seed);
      io_write(8'hEA, 8'h01); io_write(8'hEB, seed[7:0]);   latch_m[7:0]   = seed[7:0];
      io_write(8'hEA, 8'h02); io_write(8'hEB, seed[15:8]);  latch_m[13:8]  = seed[13:8];
      io_write(8'hEA, 8'h03); io_write(8'hEB, seed[23:16]); latch_m[21:14] = seed[23:16];
      check_pads("R7 output drive");
    end
    io_write(8'hEA, 8'h04); io_write(8'hEB, ~latch_m[7:0]);
    check_pads("R4 bad index write");

    // R8: special function bypass
    for (int p = 0; p < NP; p++)
      set_pin(p, (p % 2 == 0) ? 8'h08 : ((p % 3 == 0) ? 8'h09 : 8'h00));
    for (int i = 0; i < 4; i++) begin
      seed = nxt(seed); sf_out = seed[NP-1:0];
      io_write(8'hEA, 8'h01); io_write(8'hEB, seed[31:24]); latch_m[7:0] = seed[31:24];
      check_pads("R8 special");
    end

    // R9: read handshake and hold
    io_write(8'hEA, 8'h01);
    io_read(8'hEA, d, v);
    check(v == 1'b1, "R9 rvalid", 32'(v), 32'h1);
    @(negedge clk);
    check(io_rvalid == 1'b0, "R9 rvalid drop", 32'(io_rvalid), 32'h0);
    check(io_rdata == 8'h01, "R9 rdata hold", 32'(io_rdata), 32'h01);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule